// File: doc/BRIEF.md
# Instruction Phase Sequencer

This block is the control unit of a small processor. It walks each instruction through a fixed series of phases. Every instruction passes through fetch, decode and execute. An operand-read phase is added between decode and execute only when the decoded instruction takes its source from memory. A write-back phase is added after execute only when the result goes to memory.

The block holds the instruction pointer. During fetch it takes the next word from an instruction queue and latches it for the external decoder. The block does no decoding itself. The decoder reports two flags, memory source and memory destination, which the block samples during decode. The block then drives a start strobe to an external ALU and read/write requests to a memory port. Each memory request is held until the port answers with done.

A one-hot phase vector and a retire pulse are provided so that the instruction flow can be observed.

Top module: `instr_cycle_seq`

## Requirements
- R1: Synchronous active-low reset sets the instruction pointer to 0 and the phase to fetch. The phase vector is one-hot with bit 0 = fetch, bit 1 = decode, bit 2 = operand read, bit 3 = execute and bit 4 = write-back, and exactly one bit is set at all times.
- R2: In fetch with the queue not empty, the block asserts queue pop for one cycle, latches the queue word into the instruction output, increments the instruction pointer by one and moves to decode.
- R3: In fetch with the queue empty, the block does not pop, the instruction pointer keeps its value and the phase stays fetch.
- R4: Decode lasts one cycle. It moves to operand read when the memory-source flag is 1, and to execute otherwise.
- R5: Operand read asserts the memory read request and stays in that phase until memory done. In the done cycle it loads the memory read data into the operand output and moves to execute.
- R6: Execute lasts one cycle and asserts ALU start only in that cycle. It then moves to write-back when the memory-destination flag sampled in decode was 1, and to fetch otherwise.
- R7: Write-back asserts the memory write request and stays in that phase until memory done, then returns to fetch.
- R8: The retire output pulses in the last cycle of each instruction: in execute when there is no write-back, and in the done cycle of write-back otherwise.
- R9: Memory done has no effect on the phase in fetch, decode or execute. Memory read and memory write are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| q_word | input | IW | Instruction word at the head of the queue |
| q_empty | input | 1 | Queue holds no instruction |
| dec_mem_src | input | 1 | Decoder: source operand is in memory |
| dec_mem_dst | input | 1 | Decoder: result goes to memory |
| mem_done | input | 1 | Memory port finished the current request |
| mem_rdata | input | DW | Data returned by a memory read |
| q_pop | output | 1 | Remove the head word from the queue |
| instr_word | output | IW | Latched current instruction, fed to the decoder |
| instr_ptr | output | AW | Address of the next instruction |
| operand | output | DW | Operand loaded by the operand-read phase |
| alu_start | output | 1 | Tells the ALU to execute and update its status flags |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| phase_vec | output | 5 | One-hot current phase |
| retire | output | 1 | The instruction completes in this cycle |

## Verification
The embedded assertions check these rules on every cycle: the phase vector is one-hot, the pointer steps by exactly one on each pop and holds during an empty-queue stall, decode is always followed by operand read or execute, both memory phases hold until done, and read and write never overlap. Only the bench scenarios can show the values involved: that the correct queue word and read data are latched, that the memory-destination flag from decode steers execute correctly, that retire falls in the right cycle, and that a reset in the middle of an instruction restarts cleanly. For this the bench runs a reference model of the phase sequence against random queue gaps, random decoder flags and random memory latencies.

// File: rtl/seq_pkg.sv
// Package seq_pkg
// Purpose: phase type and the count of phases shared by the sequencer.
// Assumes: the enum values are the bit positions of the one-hot phase vector.
package seq_pkg;
    localparam int NUM_PHASES = 5;

    typedef enum logic [2:0] {
        PH_FETCH   = 3'd0,
        PH_DECODE  = 3'd1,
        PH_OPREAD  = 3'd2,
        PH_EXECUTE = 3'd3,
        PH_WRBACK  = 3'd4
    } phase_e;
endpackage

// File: rtl/seq_ip_counter.sv
// Module seq_ip_counter
// Purpose: holds the instruction pointer and steps it by one on each fetch pop.
// Assumes: step is asserted only in the cycle a word leaves the queue.
module seq_ip_counter #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] ip
);
    // Pointer register: cleared on reset, incremented on step.
    always_ff @(posedge clk) begin
        if (!rst_n)    ip <= '0;
        else if (step) ip <= ip + AW'(1);
    end

    assert_ip_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ip == $past(ip) + AW'(1));
    assert_ip_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(ip));
endmodule

// File: rtl/seq_phase_fsm.sv
// Module seq_phase_fsm
// Purpose: moves through fetch, decode, optional operand read, execute and
//          optional write-back, and produces the strobe for each phase.
// Assumes: the decoder flags are valid in the decode cycle, and mem_done is
//          looked at only in the two memory phases.
module seq_phase_fsm
    import seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   q_empty,
    input  logic   dec_mem_src,
    input  logic   dec_mem_dst,
    input  logic   mem_done,
    output phase_e phase,
    output logic   pop,
    output logic   opnd_load,
    output logic   alu_go,
    output logic   rd_req,
    output logic   wr_req,
    output logic   retire
);
    phase_e phase_nx;
    logic   dst_q;

    // Next-phase selection and strobes for each phase.
    always_comb begin
        phase_nx  = phase;
        pop       = 1'b0;
        opnd_load = 1'b0;
        alu_go    = 1'b0;
        rd_req    = 1'b0;
        wr_req    = 1'b0;
        retire    = 1'b0;
        unique case (phase)
            PH_FETCH: begin
                pop = !q_empty;
                if (!q_empty) phase_nx = PH_DECODE;
            end
            PH_DECODE: phase_nx = dec_mem_src ? PH_OPREAD : PH_EXECUTE;
            PH_OPREAD: begin
                rd_req    = 1'b1;
                opnd_load = mem_done;
                if (mem_done) phase_nx = PH_EXECUTE;
            end
            PH_EXECUTE: begin
                alu_go   = 1'b1;
                retire   = !dst_q;
                phase_nx = dst_q ? PH_WRBACK : PH_FETCH;
            end
            PH_WRBACK: begin
                wr_req = 1'b1;
                retire = mem_done;
                if (mem_done) phase_nx = PH_FETCH;
            end
            default: phase_nx = PH_FETCH;
        endcase
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_FETCH;
        else        phase <= phase_nx;
    end

    // Captures the memory-destination flag during decode for use in execute.
    always_ff @(posedge clk) begin
        if (!rst_n)                  dst_q <= 1'b0;
        else if (phase == PH_DECODE) dst_q <= dec_mem_dst;
    end

    assert_decode_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE) |=> (phase == PH_OPREAD || phase == PH_EXECUTE));
    assert_opread_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_OPREAD && !mem_done) |=> phase == PH_OPREAD);
    assert_wrback_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRBACK && !mem_done) |=> phase == PH_WRBACK);
    assert_fetch_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH && q_empty) |=> phase == PH_FETCH);
    assert_no_rw_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
endmodule

// File: rtl/instr_cycle_seq.sv
// Module instr_cycle_seq (top)
// Purpose: instruction phase sequencer. Holds the instruction pointer, the
//          latched instruction and the operand register, and decodes the
//          phase into a one-hot vector.
// Assumes: an external decoder looks at instr_word; the memory port holds
//          its data valid together with mem_done.
module instr_cycle_seq
    import seq_pkg::*;
#(
    parameter int IW = 16,
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IW-1:0]         q_word,
    input  logic                  q_empty,
    input  logic                  dec_mem_src,
    input  logic                  dec_mem_dst,
    input  logic                  mem_done,
    input  logic [DW-1:0]         mem_rdata,
    output logic                  q_pop,
    output logic [IW-1:0]         instr_word,
    output logic [AW-1:0]         instr_ptr,
    output logic [DW-1:0]         operand,
    output logic                  alu_start,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [NUM_PHASES-1:0] phase_vec,
    output logic                  retire
);
    phase_e phase;
    logic   opnd_load;

    seq_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .q_empty     (q_empty),
        .dec_mem_src (dec_mem_src),
        .dec_mem_dst (dec_mem_dst),
        .mem_done    (mem_done),
        .phase       (phase),
        .pop         (q_pop),
        .opnd_load   (opnd_load),
        .alu_go      (alu_start),
        .rd_req      (mem_rd),
        .wr_req      (mem_wr),
        .retire      (retire)
    );

    seq_ip_counter #(.AW(AW)) u_ip (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (q_pop),
        .ip    (instr_ptr)
    );

    // Instruction register: captures the queue head when it is popped.
    always_ff @(posedge clk) begin
        if (!rst_n)     instr_word <= '0;
        else if (q_pop) instr_word <= q_word;
    end

    // Operand register: loaded from memory when the operand read completes.
    always_ff @(posedge clk) begin
        if (!rst_n)         operand <= '0;
        else if (opnd_load) operand <= mem_rdata;
    end

    // One bit of the phase vector per phase.
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase_bit
        assign phase_vec[g] = (phase == phase_e'(g));
    end

    assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_vec) == 1);
    assert_alu_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        alu_start |=> !alu_start);
endmodule

// File: tb/instr_cycle_seq_tb_top.sv
`timescale 1ns/100ps
module instr_cycle_seq_tb_top;
    localparam int IW = 16;
    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [IW-1:0] q_word;
    logic          q_empty, dec_mem_src, dec_mem_dst, mem_done;
    logic [DW-1:0] mem_rdata;
    logic          q_pop, alu_start, mem_rd, mem_wr, retire;
    logic [IW-1:0] instr_word;
    logic [AW-1:0] instr_ptr;
    logic [DW-1:0] operand;
    logic [4:0]    phase_vec;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state
    int            m_ph;
    logic [AW-1:0] m_ip;
    logic [IW-1:0] m_instr;
    logic [DW-1:0] m_opnd;
    logic          m_dst;
    int            p_empty;
    int            p_done;

    always #2.5 clk = ~clk;

    instr_cycle_seq #(.IW(IW), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .q_word(q_word), .q_empty(q_empty),
        .dec_mem_src(dec_mem_src), .dec_mem_dst(dec_mem_dst),
        .mem_done(mem_done), .mem_rdata(mem_rdata), .q_pop(q_pop),
        .instr_word(instr_word), .instr_ptr(instr_ptr), .operand(operand),
        .alu_start(alu_start), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .phase_vec(phase_vec), .retire(retire)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] exp_vec(input int ph);
        return 5'(1 << ph);
    endfunction

    function automatic logic exp_retire(input int ph, input logic dst, input logic done);
        return (ph == 3 && !dst) || (ph == 4 && done);
    endfunction

    // Compare the outputs with the model, then step the model as one clock edge would.
    task automatic cycle_check();
        chk("R1 phase_vec", phase_vec, exp_vec(m_ph));
        chk("R2/R3 instr_ptr", instr_ptr, m_ip);
        chk("R2/R3 q_pop", q_pop, (m_ph == 0) && !q_empty);
        chk("R5 mem_rd", mem_rd, m_ph == 2);
        chk("R6 alu_start", alu_start, m_ph == 3);
        chk("R7 mem_wr", mem_wr, m_ph == 4);
        chk("R8 retire", retire, exp_retire(m_ph, m_dst, mem_done));
        chk("R9 rd_wr_excl", mem_rd & mem_wr, 0);
        if (m_ph == 1 || m_ph == 2 || m_ph == 3) chk("R2 instr_word", instr_word, m_instr);
        if (m_ph == 3) chk("R5 operand", operand, m_opnd);
        case (m_ph)
            0: if (!q_empty) begin m_instr = q_word; m_ip = m_ip + 1'b1; m_ph = 1; end
            1: begin m_dst = dec_mem_dst; m_ph = dec_mem_src ? 2 : 3; end
            2: if (mem_done) begin m_opnd = mem_rdata; m_ph = 3; end
            3: m_ph = m_dst ? 4 : 0;
            default: if (mem_done) m_ph = 0;
        endcase
    endtask

    // Drive one cycle of stimulus at the falling edge and check 1 ns later.
    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            q_empty     = ($urandom_range(99) < p_empty);
            q_word      = IW'($urandom);
            mem_done    = ($urandom_range(99) < p_done);
            mem_rdata   = DW'($urandom);
            dec_mem_src = (m_ph == 1) ? m_instr[0] : 1'($urandom);
            dec_mem_dst = (m_ph == 1) ? m_instr[1] : 1'($urandom);
            #1;
            cycle_check();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; q_empty = 1'b1; mem_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R1 reset phase", phase_vec, 5'b00001);
        chk("R1 reset ip", instr_ptr, 0);
        rst_n = 1'b1;
        m_ph = 0; m_ip = '0; m_instr = '0; m_opnd = '0; m_dst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EC0_0017));
        rst_n = 1'b0; q_word = '0; q_empty = 1'b1; dec_mem_src = 1'b0;
        dec_mem_dst = 1'b0; mem_done = 1'b0; mem_rdata = '0;
        p_empty = 20; p_done = 40;
        do_reset();
        // R3: long empty-queue stall, pointer must hold
        p_empty = 100; run_cycles(20);
        // R2/R4/R6: queue always full, memory always ready
        p_empty = 0; p_done = 100; run_cycles(200);
        // R5/R7/R9: slow memory, done is random in every phase
        p_done = 15; run_cycles(600);
        // mixed random traffic
        p_empty = 30; p_done = 50; run_cycles(1500);
        // R1: reset in the middle of an instruction, then resume
        p_empty = 0; p_done = 10; run_cycles(7);
        do_reset();
        p_empty = 25; p_done = 35; run_cycles(800);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule